// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block performs a 32-bit add, subtract or compare and derives the six arithmetic status flags from the operation: carry/borrow, low-byte parity, half-carry out of bit 3, zero, sign and signed overflow. The flags are kept in a 32-bit flags register. Each flag has a fixed bit position, because downstream branch and condition logic decodes the register by those positions. Two control flags, an interrupt-enable bit and a direction bit, live in the same register. They change only on explicit set and clear commands.

The arithmetic result is combinational. A `dest_wr` strobe tells the surrounding datapath whether the result may be written back. Compare performs a subtraction and updates the flags, but it holds `dest_wr` low. The flags register loads the new status bits on a rising clock edge when `wr_en` is high. Control-flag commands are applied on every rising edge, independently of `wr_en`.

The operation select uses an enumerated code with four values: add, subtract, compare and a reserved code. The datapath is a single shared adder. Subtraction is performed as addition of the inverted second operand plus one.

Top module: `fg_status_unit`

## Requirements
- R1: `result` is `op_a + op_b` modulo 2^32 when `op_sel` = 2'b00 (add), and `op_a - op_b` modulo 2^32 when `op_sel` = 2'b01 (subtract) or 2'b10 (compare).
- R2: Flags bit 0 (carry) is set after an add that carries out of bit 31, or after a subtract/compare where `op_a` < `op_b` as unsigned numbers.
- R3: Flags bit 2 (parity) is set when bits 7..0 of the result contain an even number of ones.
- R4: Flags bit 4 (half-carry) is set when an add carries out of bit 3, or when a subtract/compare borrows into bit 3 (`op_a[3:0]` < `op_b[3:0]`).
- R5: Flags bit 6 (zero) is set when the 32-bit result is zero. Flags bit 7 (sign) equals bit 31 of the result.
- R6: Flags bit 11 (overflow) is set for an add whose operands share a sign that differs from the result's sign. It is set for a subtract/compare whose operand signs differ and whose result sign differs from the sign of `op_a`.
- R7: `dest_wr` is 1 for add and subtract. It is 0 for compare and for the reserved code 2'b11.
- R8: The status bits (0, 2, 4, 6, 7, 11) load on a rising edge only when `wr_en` = 1 and `op_sel` is not 2'b11. Otherwise they keep their value.
- R9: Flags bit 9 (interrupt enable) and bit 10 (direction) are set by `ie_set`/`dir_set` and cleared by `ie_clr`/`dir_clr` on a rising edge. When both commands of one flag are high, clear wins. Arithmetic operations never change these bits.
- R10: The asynchronous active-low reset clears the whole flags register. Bits other than 0, 2, 4, 6, 7, 9, 10 and 11 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend for subtract/compare) |
| op_sel | input | 2 | 00 add, 01 subtract, 10 compare, 11 reserved |
| wr_en | input | 1 | Load status bits at the next rising edge |
| ie_set | input | 1 | Set interrupt-enable bit |
| ie_clr | input | 1 | Clear interrupt-enable bit |
| dir_set | input | 1 | Set direction bit |
| dir_clr | input | 1 | Clear direction bit |
| result | output | 32 | Combinational sum or difference |
| dest_wr | output | 1 | Result may be written back |
| flags | output | 32 | Flags register |

## Verification
A wrong carry-in polarity or a missing operand inversion in the shared adder shows on `result` in the same cycle the operands are applied. It also appears in the carry, half-carry and overflow bits of `flags` one edge later. A status register that loads when it should hold, or a control bit touched by an arithmetic load, shows in `flags` at the first edge after the offending input. The bench checks every bit of `flags` after each edge, so stray reserved bits and swapped bit positions are caught at that first edge.

// File: rtl/fg_pkg.sv
package fg_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_CMP  = 2'b10,
        OP_RSVD = 2'b11
    } fg_op_e;

    localparam int unsigned FLAG_W = 32;
    localparam int unsigned BIT_CF = 0;
    localparam int unsigned BIT_PF = 2;
    localparam int unsigned BIT_AF = 4;
    localparam int unsigned BIT_ZF = 6;
    localparam int unsigned BIT_SF = 7;
    localparam int unsigned BIT_IE = 9;
    localparam int unsigned BIT_DF = 10;
    localparam int unsigned BIT_OF = 11;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } fg_status_t;

endpackage

// File: rtl/fg_arith.sv
module fg_arith
    import fg_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  fg_op_e           op,
    output logic [WIDTH-1:0] res,
    output logic             cry,
    output logic             aux,
    output logic             ovf,
    output logic             wb
);
    localparam int unsigned MSB = WIDTH - 1;

    logic             sub_mode;
    logic [WIDTH-1:0] b_term;
    logic [WIDTH:0]   total;

    always_comb begin
        unique case (op)
            OP_ADD:  begin sub_mode = 1'b0; wb = 1'b1; end
            OP_SUB:  begin sub_mode = 1'b1; wb = 1'b1; end
            OP_CMP:  begin sub_mode = 1'b1; wb = 1'b0; end
            OP_RSVD: begin sub_mode = 1'b0; wb = 1'b0; end
        endcase
    end

    always_comb begin
        b_term = sub_mode ? ~opb : opb;
        total  = {1'b0, opa} + {1'b0, b_term} + {{WIDTH{1'b0}}, sub_mode};
        res    = total[MSB:0];
        cry    = total[WIDTH] ^ sub_mode;
        aux    = opa[4] ^ opb[4] ^ res[4];
        if (sub_mode)
            ovf = (opa[MSB] ^ opb[MSB]) & (res[MSB] ^ opa[MSB]);
        else
            ovf = ~(opa[MSB] ^ opb[MSB]) & (res[MSB] ^ opa[MSB]);
    end

endmodule

// File: rtl/fg_eval.sv
module fg_eval #(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned PAR_BITS = 8
) (
    input  logic [WIDTH-1:0] res,
    output logic             par,
    output logic             zero,
    output logic             sign
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [PAR_BITS-1:0] acc;

    genvar gi;
    generate
        for (gi = 0; gi < PAR_BITS; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign acc[gi] = res[gi];
            end else begin : g_rest
                assign acc[gi] = acc[gi-1] ^ res[gi];
            end
        end
    endgenerate

    assign par  = ~acc[PAR_BITS-1];
    assign zero = (res == '0);
    assign sign = res[MSB];

endmodule

// File: rtl/fg_flag_reg.sv
module fg_flag_reg
    import fg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  fg_status_t        st_in,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              dir_set,
    input  logic              dir_clr,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [FLAG_W-1:0] STATUS_MASK =
        (FLAG_W'(1) << BIT_CF) | (FLAG_W'(1) << BIT_PF) | (FLAG_W'(1) << BIT_AF) |
        (FLAG_W'(1) << BIT_ZF) | (FLAG_W'(1) << BIT_SF) | (FLAG_W'(1) << BIT_OF);

    fg_status_t st_q;
    logic       ie_q;
    logic       df_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= st_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
            df_q <= 1'b0;
        end else begin
            if (ie_clr)       ie_q <= 1'b0;
            else if (ie_set)  ie_q <= 1'b1;
            if (dir_clr)      df_q <= 1'b0;
            else if (dir_set) df_q <= 1'b1;
        end
    end

    always_comb begin
        flags_o         = '0;
        flags_o[BIT_CF] = st_q.cf;
        flags_o[BIT_PF] = st_q.pf;
        flags_o[BIT_AF] = st_q.af;
        flags_o[BIT_ZF] = st_q.zf;
        flags_o[BIT_SF] = st_q.sf;
        flags_o[BIT_OF] = st_q.of;
        flags_o[BIT_IE] = ie_q;
        flags_o[BIT_DF] = df_q;
    end

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((flags_o & STATUS_MASK) == ($past(flags_o) & STATUS_MASK))); // R8

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_set && !ie_clr && !dir_set && !dir_clr) |=>
        (flags_o[BIT_IE] == $past(flags_o[BIT_IE]) && flags_o[BIT_DF] == $past(flags_o[BIT_DF]))); // R9

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_clr || dir_clr) |=> ((!$past(ie_clr) || !flags_o[BIT_IE]) && (!$past(dir_clr) || !flags_o[BIT_DF]))); // R9

endmodule

// File: rtl/fg_status_unit.sv
module fg_status_unit
    import fg_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [1:0]        op_sel,
    input  logic              wr_en,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              dir_set,
    input  logic              dir_clr,
    output logic [WIDTH-1:0]  result,
    output logic              dest_wr,
    output logic [FLAG_W-1:0] flags
);
    fg_op_e     op_e;
    fg_status_t st_now;
    logic       cry, aux, ovf, par, zero, sign;
    logic       load;

    assign op_e = fg_op_e'(op_sel);
    assign load = wr_en && (op_e != OP_RSVD);

    fg_arith #(.WIDTH(WIDTH)) u_arith (
        .opa (op_a),
        .opb (op_b),
        .op  (op_e),
        .res (result),
        .cry (cry),
        .aux (aux),
        .ovf (ovf),
        .wb  (dest_wr)
    );

    fg_eval #(.WIDTH(WIDTH), .PAR_BITS(8)) u_eval (
        .res  (result),
        .par  (par),
        .zero (zero),
        .sign (sign)
    );

    always_comb begin
        st_now.cf = cry;
        st_now.pf = par;
        st_now.af = aux;
        st_now.zf = zero;
        st_now.sf = sign;
        st_now.of = ovf;
    end

    fg_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .st_in   (st_now),
        .ie_set  (ie_set),
        .ie_clr  (ie_clr),
        .dir_set (dir_set),
        .dir_clr (dir_clr),
        .flags_o (flags)
    );

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00) |-> (result == op_a + op_b)); // R1

    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (flags[BIT_ZF] == ($past(result) == '0))); // R5

    AST_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op_sel != 2'b00) |=> (flags[BIT_CF] == ($past(op_a) < $past(op_b)))); // R2

    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[1]) |-> !dest_wr); // R7

endmodule

// File: tb/fg_status_unit_test.sv
module fg_status_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  op_sel = 2'b00;
    logic        wr_en = 1'b0, ie_set = 1'b0, ie_clr = 1'b0, dir_set = 1'b0, dir_clr = 1'b0;
    logic [31:0] result;
    logic        dest_wr;
    logic [31:0] flags;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_flags = '0;

    always #10 clk = ~clk;

    fg_status_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .wr_en(wr_en), .ie_set(ie_set), .ie_clr(ie_clr), .dir_set(dir_set),
        .dir_clr(dir_clr), .result(result), .dest_wr(dest_wr), .flags(flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_status(input logic [31:0] a, input logic [31:0] b,
                                                 input logic [1:0] op);
        logic [32:0] s;
        logic [31:0] r, f;
        f = '0;
        if (op == 2'b00) begin
            s = {1'b0, a} + {1'b0, b};
            r = s[31:0];
            f[0]  = s[32];
            f[4]  = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            f[11] = (a[31] == b[31]) && (r[31] != a[31]);
        end else begin
            r = a - b;
            f[0]  = a < b;
            f[4]  = a[3:0] < b[3:0];
            f[11] = (a[31] != b[31]) && (r[31] != a[31]);
        end
        f[2] = ~(^r[7:0]);
        f[6] = (r == 32'd0);
        f[7] = r[31];
        return f;
    endfunction

    task automatic apply_op(input string req, input logic [31:0] a, input logic [31:0] b,
                            input logic [1:0] op, input logic we,
                            input logic is, input logic ic, input logic ds, input logic dc);
        logic [31:0] exp_res;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; wr_en = we;
        ie_set = is; ie_clr = ic; dir_set = ds; dir_clr = dc;
        #1;
        exp_res = (op == 2'b00) ? a + b : a - b;
        if (op != 2'b11) chk({req, "/R1 result"}, result, exp_res);
        chk({req, "/R7 dest_wr"}, {31'd0, dest_wr}, {31'd0, (op == 2'b00 || op == 2'b01)});
        if (we && op != 2'b11)
            exp_flags = (exp_flags & 32'h0000_0600) | model_status(a, b, op);
        if (ic) exp_flags[9] = 1'b0; else if (is) exp_flags[9] = 1'b1;
        if (dc) exp_flags[10] = 1'b0; else if (ds) exp_flags[10] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; ie_set = 1'b0; ie_clr = 1'b0; dir_set = 1'b0; dir_clr = 1'b0;
        chk({req, " flags"}, flags, exp_flags);
    endtask

    task automatic t_reset();
        #1;
        chk("R10 reset", flags, 32'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R10 after release", flags, 32'd0);
    endtask

    task automatic t_add();
        apply_op("R3 add small",       32'd1,         32'd2,         2'b00, 1, 0, 0, 0, 0);
        apply_op("R2 add carry/zero",  32'hFFFF_FFFF, 32'd1,         2'b00, 1, 0, 0, 0, 0);
        apply_op("R6 add overflow",    32'h7FFF_FFFF, 32'd1,         2'b00, 1, 0, 0, 0, 0);
        apply_op("R6 add neg overflow",32'h8000_0000, 32'h8000_0000, 2'b00, 1, 0, 0, 0, 0);
        apply_op("R4 add half-carry",  32'h0000_0008, 32'h0000_0008, 2'b00, 1, 0, 0, 0, 0);
    endtask

    task automatic t_sub();
        apply_op("R2 sub borrow",      32'd0,         32'd1,         2'b01, 1, 0, 0, 0, 0);
        apply_op("R6 sub overflow",    32'h8000_0000, 32'd1,         2'b01, 1, 0, 0, 0, 0);
        apply_op("R4 sub low borrow",  32'h0000_0010, 32'h0000_0001, 2'b01, 1, 0, 0, 0, 0);
        apply_op("R5 sub sign",        32'd5,         32'd9,         2'b01, 1, 0, 0, 0, 0);
    endtask

    task automatic t_cmp();
        apply_op("R7 cmp equal",       32'h1234_5678, 32'h1234_5678, 2'b10, 1, 0, 0, 0, 0);
        apply_op("R5 cmp less",        32'd3,         32'd7,         2'b10, 1, 0, 0, 0, 0);
    endtask

    task automatic t_hold();
        apply_op("R8 no write",        32'hFFFF_FFFF, 32'd1,         2'b00, 0, 0, 0, 0, 0);
        apply_op("R8 reserved op",     32'd0,         32'd1,         2'b11, 1, 0, 0, 0, 0);
    endtask

    task automatic t_ctrl();
        apply_op("R9 set ie",          32'd0, 32'd0, 2'b00, 0, 1, 0, 0, 0);
        apply_op("R9 set dir",         32'd0, 32'd0, 2'b00, 0, 0, 0, 1, 0);
        apply_op("R9 arith keeps ctl", 32'hFFFF_FFFF, 32'd1, 2'b00, 1, 0, 0, 0, 0);
        apply_op("R9 clear wins ie",   32'd0, 32'd0, 2'b00, 0, 1, 1, 0, 0);
        apply_op("R9 clear wins dir",  32'd0, 32'd0, 2'b00, 0, 0, 0, 1, 1);
        apply_op("R10 unused bits",    32'd0, 32'd0, 2'b01, 1, 1, 0, 1, 0);
    endtask

    task automatic t_sweep();
        logic [31:0] seed = 32'h1357_9BDF;
        logic [31:0] a, b;
        for (int i = 0; i < 60; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            b = (i % 4 == 0) ? a : seed;
            apply_op("R6 sweep", a, b, 2'(i % 3), 1, 0, 0, 0, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_hold();
        t_ctrl();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule